// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Digital Loop Filter

This block is the digital loop filter of a bang-bang clock recovery loop. Once per bit it receives a three-level phase decision from the phase detector (early, late, or no transition) and drives two separate commands toward the oscillator's current DACs. The proportional path forwards each decision with a single register of delay. The integral path runs at one quarter of the bit rate. It gathers four decisions, reduces them to one vote and adds the vote into a wide saturating accumulator. A second-order delta-sigma truncator then turns the accumulator's upper bits into a three-level integral command.

The two paths are never summed. The proportional step is one full DAC step per decision. One vote moves the mean integral drive by only 1/8192 of a step, so the loop stays strongly over-damped. A programmable mid-code is loaded into the accumulator during reset. This gives the integral path a known starting frequency word.

Top module: `bb_loop_filter`

## Requirements
- R1: The decision input `decIn` is decoded as 2'b01 = +1 (early), 2'b11 = -1 (late), and 2'b00 or 2'b10 = 0 (no transition).
- R2: `propCode` equals the decoded value of the decision sampled at the previous rising edge, as a signed two-bit code (01 = +1, 11 = -1, 00 = 0).
- R3: Counting from the first edge after reset release, each run of four consecutive decisions forms one group. The group's vote is +1 if the sum of its four decoded values is positive, -1 if the sum is negative, and 0 if the sum is zero.
- R4: The accumulator is a 14-bit two's-complement register. It loads `midCode` while `rstN` is low. It changes only at the edge that samples a group's fourth decision, and then only by that group's vote.
- R5: The accumulator saturates: a +1 vote at +8191 leaves it at +8191, and a -1 vote at -8192 leaves it at -8192.
- R6: On each integral update the modulator takes x = accumulator >>> 3, the top 11 bits, signed. It forms v = x + 2·e1 - e2 from its last two stored errors. It outputs y = +1 if v >= 512, y = -1 if v < -512, and y = 0 otherwise. It then stores the new error e = v - 1024·y, clamped to [-1024, +1024]. `intCmd` carries y encoded as in R2.
- R7: `intCmd` changes only at the edge one clock after a group's fourth decision. `intValid` is high for exactly the cycle that follows that edge. Reset clears `propCode`, `intCmd`, `intValid`, the group position and both modulator errors.
- R8: `propCode` never depends on the accumulator or the modulator. With all decisions zero it stays 0 whatever the integral state.
- R9: With the accumulator held at a constant value A, the integral commands over N updates sum to within ±4 of N·A/8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Synchronous active-low reset |
| decIn | input | 2 | Phase decision for the current bit (R1 encoding) |
| midCode | input | 14 | Signed accumulator value loaded during reset |
| propCode | output | 2 | Signed proportional DAC command, one cycle after the decision |
| intCmd | output | 2 | Signed three-level integral DAC command, held between updates |
| intValid | output | 1 | One-cycle strobe marking a new `intCmd` |

## Verification
Every fourth cycle the proportional register and the integral group close at the same edge. In the following cycle the modulator update coincides with the next proportional update. The bench drives random and directed decisions across these boundaries, including edge-heavy groups and reserved codes. It then checks each cycle that `propCode` follows only the current decision, while `intCmd` and `intValid` follow an independent bench model of voting, saturation and the modulator. Directed resets sit just below the modulator's decision threshold, so that a single vote visibly flips the command. Saturation runs confirm that the accumulator clamps at its limits instead of wrapping.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic [1:0] {
    DEC_NONE  = 2'b00,
    DEC_EARLY = 2'b01,
    DEC_RSVD  = 2'b10,
    DEC_LATE  = 2'b11
  } dec_code_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic grpLast;   // current decision is the last of its group
    logic dsmStep;   // run the modulator on the freshly updated accumulator
  } lf_strobe_t;

  function automatic logic signed [1:0] decToVal(input logic [1:0] code);
    logic signed [1:0] val;
    case (code)
      DEC_EARLY: val = 2'sb01;
      DEC_LATE:  val = 2'sb11;
      default:   val = 2'sb00;   // none or reserved code
    endcase
    return val;
  endfunction

endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  logic       clk,
  input  logic       rstN,
  output lf_strobe_t strobe
);

  localparam int CW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [CW-1:0] LAST = CW'(GROUP - 1);

  logic [CW-1:0] slot;
  logic          dsmQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot <= '0;
      dsmQ <= 1'b0;
    end else begin
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
      dsmQ <= (slot == LAST);
    end
  end

  assign strobe.grpLast = (slot == LAST);
  assign strobe.dsmStep = dsmQ;

  AST_GROUP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grpLast |=> !strobe.grpLast); // R3

endmodule

// File: rtl/lf_dsm2.sv
module lf_dsm2 #(
  parameter int DSM_W = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    step,
  input  logic signed [DSM_W-1:0] xIn,
  output logic signed [1:0]       cmdOut,
  output logic                    validOut
);

  localparam int EW = DSM_W + 1;
  localparam int VW = DSM_W + 3;
  localparam int Q  = 2 ** (DSM_W - 1);
  localparam logic signed [VW-1:0] Q_V    = VW'(Q);
  localparam logic signed [VW-1:0] HALF_V = VW'(Q / 2);
  localparam logic signed [1:0] CMD_POS  = 2'sb01;
  localparam logic signed [1:0] CMD_NEG  = 2'sb11;
  localparam logic signed [1:0] CMD_ZERO = 2'sb00;

  logic signed [EW-1:0] err1, err2, errNew;
  logic signed [VW-1:0] vSum, resid, residClamp;
  logic signed [1:0]    yNext;

  always_comb begin
    vSum = VW'(xIn) + (VW'(err1) <<< 1) - VW'(err2);
    if (vSum >= HALF_V) begin
      yNext = CMD_POS;
      resid = vSum - Q_V;
    end else if (vSum < -HALF_V) begin
      yNext = CMD_NEG;
      resid = vSum + Q_V;
    end else begin
      yNext = CMD_ZERO;
      resid = vSum;
    end
    if (resid > Q_V)       residClamp = Q_V;
    else if (resid < -Q_V) residClamp = -Q_V;
    else                   residClamp = resid;
    errNew = EW'(residClamp);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      err1     <= '0;
      err2     <= '0;
      cmdOut   <= CMD_ZERO;
      validOut <= 1'b0;
    end else begin
      validOut <= step;
      if (step) begin
        cmdOut <= yNext;
        err1   <= errNew;
        err2   <= err1;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut); // R7
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> $stable(cmdOut)); // R7
  AST_CMD_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut != 2'sb10); // R6

endmodule

// File: rtl/lf_datapath.sv
module lf_datapath
  import lf_pkg::*;
#(
  parameter int GROUP = 4,
  parameter int ACC_W = 14,
  parameter int DSM_W = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              decIn,
  input  logic signed [ACC_W-1:0] midCode,
  input  lf_strobe_t              strobe,
  output logic signed [1:0]       propCode,
  output logic signed [1:0]       intCmd,
  output logic                    intValid
);

  localparam int SW   = $clog2(GROUP) + 2;
  localparam int NBUF = GROUP - 1;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [1:0]       decVal;
  logic signed [1:0]       decBuf [NBUF];
  logic signed [SW-1:0]    groupSum;
  logic signed [1:0]       vote;
  logic signed [ACC_W-1:0] acc, accNext;
  logic signed [DSM_W-1:0] dsmIn;

  assign decVal = decToVal(decIn);

  // Proportional path: one register, bit rate
  always_ff @(posedge clk) begin
    if (!rstN) propCode <= 2'sb00;
    else       propCode <= decVal;
  end

  // Sliding window of the previous GROUP-1 decisions
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NBUF; i++) decBuf[i] <= 2'sb00;
    end else begin
      decBuf[0] <= decVal;
      for (int i = 1; i < NBUF; i++) decBuf[i] <= decBuf[i-1];
    end
  end

  always_comb begin
    groupSum = SW'(decVal);
    for (int i = 0; i < NBUF; i++) groupSum = groupSum + SW'(decBuf[i]);
    if (groupSum > 0)      vote = 2'sb01;
    else if (groupSum < 0) vote = 2'sb11;
    else                   vote = 2'sb00;
  end

  // Saturating integral accumulator
  always_comb begin
    if (vote == 2'sb01 && acc == ACC_MAX)      accNext = acc;
    else if (vote == 2'sb11 && acc == ACC_MIN) accNext = acc;
    else accNext = acc + {{(ACC_W-2){vote[1]}}, vote};
  end

  always_ff @(posedge clk) begin
    if (!rstN)               acc <= midCode;
    else if (strobe.grpLast) acc <= accNext;
  end

  assign dsmIn = acc[ACC_W-1 -: DSM_W];

  lf_dsm2 #(.DSM_W(DSM_W)) u_dsm (
    .clk      (clk),
    .rstN     (rstN),
    .step     (strobe.dsmStep),
    .xIn      (dsmIn),
    .cmdOut   (intCmd),
    .validOut (intValid)
  );

  AST_PROP_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> propCode == $past(decVal)); // R2
  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.grpLast |=> acc == $past(acc)); // R4
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grpLast |=> (acc == $past(acc)) || (acc == $past(acc) + ACC_W'(1))
                       || (acc == $past(acc) - ACC_W'(1))); // R4
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grpLast && acc == ACC_MAX && vote == 2'sb01) |=> acc == ACC_MAX); // R5
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grpLast && acc == ACC_MIN && vote == 2'sb11) |=> acc == ACC_MIN); // R5

endmodule

// File: rtl/bb_loop_filter.sv
module bb_loop_filter
  import lf_pkg::*;
#(
  parameter int GROUP = 4,
  parameter int ACC_W = 14,
  parameter int DSM_W = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              decIn,
  input  logic signed [ACC_W-1:0] midCode,
  output logic signed [1:0]       propCode,
  output logic signed [1:0]       intCmd,
  output logic                    intValid
);

  lf_strobe_t strobe;

  lf_ctrl #(.GROUP(GROUP)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  lf_datapath #(.GROUP(GROUP), .ACC_W(ACC_W), .DSM_W(DSM_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .decIn    (decIn),
    .midCode  (midCode),
    .strobe   (strobe),
    .propCode (propCode),
    .intCmd   (intCmd),
    .intValid (intValid)
  );

endmodule

// File: tb/bb_loop_filter_tb.sv
module bb_loop_filter_tb;

  localparam int ACC_W = 14;
  localparam int DSM_W = 11;
  localparam int GROUP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] decIn = 2'b00;
  logic signed [ACC_W-1:0] midCode = '0;
  logic signed [1:0] propCode, intCmd;
  logic intValid;

  bb_loop_filter #(.GROUP(GROUP), .ACC_W(ACC_W), .DSM_W(DSM_W)) u_dut (
    .clk(clk), .rstN(rstN), .decIn(decIn), .midCode(midCode),
    .propCode(propCode), .intCmd(intCmd), .intValid(intValid)
  );

  always #5 clk = ~clk;

  int nTotal = 0, nBad = 0;
  bit finished = 1'b0;
  int mCnt, mSum, mAcc, mE1, mE2, expProp, expInt;
  bit mPend, expValid;
  int intSum = 0;
  bit collect = 1'b0;
  int negSeen;
  localparam int ACC_MAX = 2 ** (ACC_W - 1) - 1;
  localparam int ACC_MIN = -(2 ** (ACC_W - 1));
  localparam int QV = 2 ** (DSM_W - 1);

  function automatic int decToInt(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nTotal++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(int mid);
    @(negedge clk);
    rstN = 1'b0;
    midCode = ACC_W'(mid);
    decIn = 2'b00;
    repeat (2) @(negedge clk);
    mCnt = 0; mSum = 0; mAcc = mid; mE1 = 0; mE2 = 0; mPend = 1'b0;
    expProp = 0; expInt = 0; expValid = 1'b0;
    rstN = 1'b1;
    check(int'(propCode) == 0, "R7 reset propCode", int'(propCode), 0);
    check(int'(intCmd) == 0, "R7 reset intCmd", int'(intCmd), 0);
    check(intValid == 1'b0, "R7 reset intValid", int'(intValid), 0);
  endtask

  task automatic step(logic [1:0] code);
    int dv, x, v, y, r, s, vt;
    decIn = code;
    @(posedge clk);
    dv = decToInt(code);
    expProp = dv;
    expValid = mPend;
    if (mPend) begin
      x = mAcc >>> (ACC_W - DSM_W);
      v = x + 2 * mE1 - mE2;
      y = (v >= QV / 2) ? 1 : ((v < -(QV / 2)) ? -1 : 0);
      r = v - y * QV;
      if (r > QV) r = QV;
      if (r < -QV) r = -QV;
      mE2 = mE1; mE1 = r; expInt = y;
    end
    if (mCnt == GROUP - 1) begin
      s = mSum + dv;
      vt = (s > 0) ? 1 : ((s < 0) ? -1 : 0);
      mAcc = mAcc + vt;
      if (mAcc > ACC_MAX) mAcc = ACC_MAX;
      if (mAcc < ACC_MIN) mAcc = ACC_MIN;
      mSum = 0; mPend = 1'b1;
    end else begin
      mSum = mSum + dv; mPend = 1'b0;
    end
    mCnt = (mCnt + 1) % GROUP;
    @(negedge clk);
    check(int'(propCode) == expProp, "R1 R2 R8 proportional", int'(propCode), expProp);
    check(intValid == expValid, "R7 strobe", int'(intValid), int'(expValid));
    check(int'(intCmd) == expInt, "R3 R4 R5 R6 R7 integral", int'(intCmd), expInt);
    if (intValid && collect) intSum += int'(intCmd);
    if (intValid && int'(intCmd) < 0) negSeen++;
  endtask

  task automatic group4(logic [1:0] a, logic [1:0] b, logic [1:0] c, logic [1:0] d);
    step(a); step(b); step(c); step(d);
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    doReset(0);
    repeat (1200) step(2'($urandom_range(0, 3)));

    // R3 positive majority flips the command just above threshold
    doReset(4095); group4(2'b01, 2'b01, 2'b11, 2'b00); step(2'b00);
    check(int'(intCmd) == 1, "R3 early majority", int'(intCmd), 1);
    // R3 tie gives no vote
    doReset(4095); group4(2'b01, 2'b11, 2'b00, 2'b00); step(2'b00);
    check(int'(intCmd) == 0, "R3 tie vote", int'(intCmd), 0);
    // R1 reserved code counts as no transition
    doReset(4095); group4(2'b10, 2'b10, 2'b10, 2'b10); step(2'b00);
    check(int'(intCmd) == 0, "R1 reserved code", int'(intCmd), 0);
    // R3 late majority pulls below threshold
    doReset(4096); group4(2'b11, 2'b11, 2'b01, 2'b00); step(2'b00);
    check(int'(intCmd) == 0, "R3 late majority", int'(intCmd), 0);

    // R5 positive saturation
    doReset(8190);
    repeat (8) group4(2'b01, 2'b01, 2'b01, 2'b01);
    negSeen = 0;
    repeat (20) group4(2'b01, 2'b01, 2'b01, 2'b01);
    check(negSeen == 0, "R5 no wrap at top", negSeen, 0);
    repeat (4) group4(2'b11, 2'b11, 2'b11, 2'b11);
    // R5 negative saturation
    doReset(-8191);
    repeat (30) group4(2'b11, 2'b11, 2'b11, 2'b00);
    repeat (4) group4(2'b01, 2'b01, 2'b00, 2'b00);

    // R9 mean integral drive
    doReset(2048);
    intSum = 0; collect = 1'b1;
    repeat (256 * GROUP) step(2'b00);
    collect = 1'b0;
    check((intSum >= 60) && (intSum <= 68), "R9 mean drive", intSum, 64);

    // Reset in the middle of a group
    doReset(0); step(2'b01); step(2'b01);
    doReset(100);
    repeat (400) step(2'($urandom_range(0, 3)));

    // Random mid-codes
    repeat (3) begin
      doReset(int'($urandom_range(0, 16383)) - 8192);
      repeat (800) step(2'($urandom_range(0, 3)));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nTotal, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTotal++; nBad++;
      $display("FAIL watchdog R1 R7 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", nTotal, nBad);
      $finish;
    end
  end

endmodule